// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Data Cache

This block is a small data cache that sits between a processor load/store port and a slower line-oriented memory. It holds four 4-byte lines, arranged as two sets of two ways, over a 12-bit byte address. A request names a byte or a whole line. Hits are answered from the cache alone. A miss picks a victim way in the addressed set. If the victim is dirty it is written back first. The missing line is then fetched, installed, and any store data is merged into it.

Processor requests use a valid/ready handshake and are taken one at a time. Every accepted request ends in a one-cycle response that carries the read data and a flag saying whether it hit. On the memory side, one request channel carries both write-backs and refill reads, addressed by 10-bit line address. Refill data comes back on a separate valid strobe.

Top module: `sa2_wb_cache`

## Requirements
- R1: Byte address bits [11:3] are the tag, bit [2] selects the set and bits [1:0] give the byte within the line. An access to one set never disturbs what the other set holds.
- R2: Reset empties every way, clears every dirty flag and points each set's replacement bit at way 0. While in reset and right after it, `req_ready_o` is 1, `resp_valid_o` is 0 and `mem_req_valid_o` is 0. Lines that were dirty before reset are dropped without being written back.
- R3: On a miss, an empty way of the set is filled before any valid way is replaced.
- R4: With both ways valid, a miss replaces the least recently used way. The filled way becomes most recent.
- R5: A miss fetches the whole 4-byte line, so later accesses to the other bytes of that line hit.
- R6: A hit on either way makes that way most recent, and the other way becomes the next victim.
- R7: A store hit changes only the cached line and marks it dirty. It causes no memory request.
- R8: A dirty victim is written to memory (write=1) at line address {victim tag, set}, carrying its full line. This transfer completes before the refill read is requested. A clean victim causes no memory write.
- R9: A store miss allocates the line: the line is refilled, the store data is merged in, and the line is marked dirty.
- R10: A byte read returns the addressed byte zero-extended in bits [7:0]. A word read (`req_word_i`=1) returns the whole line, with byte 0 in bits [7:0]. A byte store writes only the lane picked by bits [1:0]. A word store replaces the line.
- R11: A request is accepted on a clock edge where `req_valid_i` and `req_ready_o` are both 1, and `req_ready_o` stays 0 until the response. A hit responds one cycle after acceptance. A clean miss responds one cycle after the refill data arrives. `resp_valid_o` is a one-cycle pulse.
- R12: While `mem_req_valid_o` is 1 and `mem_req_ready_i` is 0, the request's address, write flag and data hold steady.
- R13: Two lines that share a set index but have different tags can both stay resident and hit in turn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Processor request present |
| req_ready_o | output | 1 | Cache idle and able to take a request |
| req_write_i | input | 1 | 1 = store, 0 = load |
| req_word_i | input | 1 | 1 = whole-line access, 0 = single byte |
| req_addr_i | input | 12 | Byte address |
| req_wdata_i | input | 32 | Store data (byte stores use bits [7:0]) |
| resp_valid_o | output | 1 | One-cycle response strobe |
| resp_hit_o | output | 1 | Response came from a hit |
| resp_rdata_o | output | 32 | Read data |
| mem_req_valid_o | output | 1 | Memory request present |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_req_write_o | output | 1 | 1 = write-back, 0 = refill read |
| mem_req_addr_o | output | 10 | Line address |
| mem_req_wdata_o | output | 32 | Write-back line data |
| mem_rsp_valid_i | input | 1 | Refill data present |
| mem_rsp_data_i | input | 32 | Refill line data |

## Verification
Acceptance and response are both counted at falling edges. When memory answers a refill on the cycle after its handshake, the response shows up at the 2nd falling edge after the accepting rising edge on a hit, the 4th on a clean miss and the 5th on a dirty miss. Each extra cycle that memory holds ready low adds one more. The bench drives inputs at a falling edge, counts falling edges until `resp_valid_o` appears, and compares that count exactly with the expected one. Hit flag and data are read at that same falling edge. The memory model records every write-back and refill handshake with its order, so write-back content, write-back ordering and the absence of traffic are checked against the same count.

// File: rtl/sa2c_pkg.sv
package sa2c_pkg;
  parameter int ADDR_W = 12;
  parameter int OFS_W  = 2;
  parameter int IDX_W  = 1;
  parameter int WAYS   = 2;

  localparam int TAG_W   = ADDR_W - IDX_W - OFS_W;
  localparam int SETS    = 1 << IDX_W;
  localparam int LINE_B  = 1 << OFS_W;
  localparam int LINE_W  = 8 * LINE_B;
  localparam int LADDR_W = ADDR_W - OFS_W;
  localparam int WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1;

  typedef logic [LINE_W-1:0] line_t;
  typedef logic [TAG_W-1:0]  tag_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WB,
    ST_FILL_REQ,
    ST_FILL_WAIT
  } cst_e;

  // store merge: whole line or one byte lane
  function automatic line_t merge_line(line_t old, line_t wd, logic word,
                                       logic [OFS_W-1:0] ofs);
    line_t r;
    r = old;
    if (word) r = wd;
    else      r[{ofs, 3'b000} +: 8] = wd[7:0];
    return r;
  endfunction

  // load view: whole line or zero-extended byte
  function automatic line_t pick_data(line_t ln, logic word, logic [OFS_W-1:0] ofs);
    line_t r;
    if (word) r = ln;
    else      r = {{(LINE_W-8){1'b0}}, ln[{ofs, 3'b000} +: 8]};
    return r;
  endfunction
endpackage

// File: rtl/sa2c_tag_store.sv
module sa2c_tag_store
  import sa2c_pkg::*;
(
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [IDX_W-1:0]            set_i,
  input  tag_t                        tag_i,
  output logic [WAYS-1:0]             hit_o,
  output logic [WAYS-1:0]             vld_o,
  output logic [WAYS-1:0]             dirty_o,
  output logic [WAYS-1:0][TAG_W-1:0]  vtag_o,
  input  logic                        we_i,
  input  logic [WAY_W-1:0]            way_i,
  input  logic                        wr_dirty_i
);
  logic [SETS-1:0][WAYS-1:0]             v_q;
  logic [SETS-1:0][WAYS-1:0]             d_q;
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  t_q;

  for (genvar s = 0; s < SETS; s++) begin : g_set
    localparam logic [IDX_W-1:0] SI = IDX_W'(s);
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      localparam logic [WAY_W-1:0] WI = WAY_W'(w);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          v_q[s][w] <= 1'b0;
          d_q[s][w] <= 1'b0;
          t_q[s][w] <= '0;
        end else if (we_i && set_i == SI && way_i == WI) begin
          v_q[s][w] <= 1'b1;
          d_q[s][w] <= wr_dirty_i;
          t_q[s][w] <= tag_i;
        end
      end
    end
  end

  // both ways of the addressed set compared in parallel
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    always_comb begin
      vld_o[w]   = v_q[set_i][w];
      dirty_o[w] = d_q[set_i][w];
      vtag_o[w]  = t_q[set_i][w];
      hit_o[w]   = v_q[set_i][w] && (t_q[set_i][w] == tag_i);
    end
  end
endmodule

// File: rtl/sa2c_lru.sv
module sa2c_lru
  import sa2c_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [IDX_W-1:0]   set_i,
  input  logic               upd_i,
  input  logic [WAY_W-1:0]   used_i,
  output logic [WAY_W-1:0]   lru_o
);
  logic [SETS-1:0][WAY_W-1:0] lru_q;

  for (genvar s = 0; s < SETS; s++) begin : g_set
    localparam logic [IDX_W-1:0] SI = IDX_W'(s);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  lru_q[s] <= '0;
      else if (upd_i && set_i == SI) lru_q[s] <= ~used_i;  // other way is next victim
    end
  end

  assign lru_o = lru_q[set_i];
endmodule

// File: rtl/sa2c_line_store.sv
module sa2c_line_store
  import sa2c_pkg::*;
(
  input  logic                         clk_i,
  input  logic [IDX_W-1:0]             set_i,
  input  logic                         we_i,
  input  logic [WAY_W-1:0]             way_i,
  input  line_t                        wline_i,
  output logic [WAYS-1:0][LINE_W-1:0]  rline_o
);
  logic [SETS-1:0][WAYS-1:0][LINE_W-1:0] mem_q;

  for (genvar s = 0; s < SETS; s++) begin : g_set
    localparam logic [IDX_W-1:0] SI = IDX_W'(s);
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      localparam logic [WAY_W-1:0] WI = WAY_W'(w);
      always_ff @(posedge clk_i) begin
        if (we_i && set_i == SI && way_i == WI) mem_q[s][w] <= wline_i;
      end
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    assign rline_o[w] = mem_q[set_i][w];
  end
endmodule

// File: rtl/sa2c_ctrl.sv
module sa2c_ctrl
  import sa2c_pkg::*;
(
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         req_valid_i,
  output logic                         req_ready_o,
  input  logic                         req_write_i,
  input  logic                         req_word_i,
  input  logic [ADDR_W-1:0]            req_addr_i,
  input  line_t                        req_wdata_i,
  output logic                         resp_valid_o,
  output logic                         resp_hit_o,
  output line_t                        resp_rdata_o,
  output logic                         mem_req_valid_o,
  input  logic                         mem_req_ready_i,
  output logic                         mem_req_write_o,
  output logic [LADDR_W-1:0]           mem_req_addr_o,
  output line_t                        mem_req_wdata_o,
  input  logic                         mem_rsp_valid_i,
  input  line_t                        mem_rsp_data_i,
  output logic [IDX_W-1:0]             set_o,
  output tag_t                         tag_o,
  input  logic [WAYS-1:0]              hit_i,
  input  logic [WAYS-1:0]              vld_i,
  input  logic [WAYS-1:0]              dirty_i,
  input  logic [WAYS-1:0][TAG_W-1:0]   vtag_i,
  input  logic [WAYS-1:0][LINE_W-1:0]  rline_i,
  input  logic [WAY_W-1:0]             lru_i,
  output logic                         tag_we_o,
  output logic [WAY_W-1:0]             wr_way_o,
  output logic                         wr_dirty_o,
  output logic                         data_we_o,
  output line_t                        wline_o,
  output logic                         lru_upd_o,
  output logic [WAY_W-1:0]             lru_used_o
);
  cst_e               st_q, st_d;
  logic               r_write_q, r_word_q;
  logic [ADDR_W-1:0]  r_addr_q;
  line_t              r_wdata_q;
  logic [WAY_W-1:0]   vic_q, vic_d, hit_way;
  logic               hit_any;
  logic [OFS_W-1:0]   r_ofs;
  line_t              hit_new, fill_new;
  logic               resp_set, resp_hit_d;
  line_t              resp_data_d;
  logic               resp_valid_q, resp_hit_q;
  line_t              resp_rdata_q;

  assign r_ofs       = r_addr_q[OFS_W-1:0];
  assign set_o       = r_addr_q[OFS_W +: IDX_W];
  assign tag_o       = r_addr_q[ADDR_W-1 -: TAG_W];
  assign req_ready_o = (st_q == ST_IDLE);
  assign hit_any     = |hit_i;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) if (hit_i[w]) hit_way = WAY_W'(w);
  end

  // lowest empty way first, otherwise the LRU way
  always_comb begin
    vic_d = lru_i;
    for (int w = WAYS-1; w >= 0; w--) if (!vld_i[w]) vic_d = WAY_W'(w);
  end

  assign hit_new  = merge_line(rline_i[hit_way], r_wdata_q, r_word_q, r_ofs);
  assign fill_new = r_write_q ? merge_line(mem_rsp_data_i, r_wdata_q, r_word_q, r_ofs)
                              : mem_rsp_data_i;

  always_comb begin
    st_d            = st_q;
    mem_req_valid_o = 1'b0;
    mem_req_write_o = 1'b0;
    mem_req_addr_o  = r_addr_q[ADDR_W-1:OFS_W];
    mem_req_wdata_o = '0;
    tag_we_o        = 1'b0;
    data_we_o       = 1'b0;
    wr_way_o        = vic_q;
    wr_dirty_o      = r_write_q;
    wline_o         = fill_new;
    lru_upd_o       = 1'b0;
    lru_used_o      = vic_q;
    resp_set        = 1'b0;
    resp_hit_d      = 1'b0;
    resp_data_d     = pick_data(fill_new, r_word_q, r_ofs);
    unique case (st_q)
      ST_IDLE: if (req_valid_i) st_d = ST_LOOKUP;
      ST_LOOKUP: begin
        if (hit_any) begin
          lru_upd_o   = 1'b1;
          lru_used_o  = hit_way;
          wr_way_o    = hit_way;
          wr_dirty_o  = 1'b1;
          wline_o     = hit_new;
          tag_we_o    = r_write_q;
          data_we_o   = r_write_q;
          resp_set    = 1'b1;
          resp_hit_d  = 1'b1;
          resp_data_d = pick_data(r_write_q ? hit_new : rline_i[hit_way], r_word_q, r_ofs);
          st_d        = ST_IDLE;
        end else if (vld_i[vic_d] && dirty_i[vic_d]) begin
          st_d = ST_WB;
        end else begin
          st_d = ST_FILL_REQ;
        end
      end
      ST_WB: begin
        mem_req_valid_o = 1'b1;
        mem_req_write_o = 1'b1;
        mem_req_addr_o  = {vtag_i[vic_q], set_o};
        mem_req_wdata_o = rline_i[vic_q];
        if (mem_req_ready_i) st_d = ST_FILL_REQ;
      end
      ST_FILL_REQ: begin
        mem_req_valid_o = 1'b1;
        if (mem_req_ready_i) st_d = ST_FILL_WAIT;
      end
      ST_FILL_WAIT: begin
        if (mem_rsp_valid_i) begin
          tag_we_o  = 1'b1;
          data_we_o = 1'b1;
          lru_upd_o = 1'b1;
          resp_set  = 1'b1;
          st_d      = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      r_write_q    <= 1'b0;
      r_word_q     <= 1'b0;
      r_addr_q     <= '0;
      r_wdata_q    <= '0;
      vic_q        <= '0;
      resp_valid_q <= 1'b0;
      resp_hit_q   <= 1'b0;
      resp_rdata_q <= '0;
    end else begin
      st_q         <= st_d;
      resp_valid_q <= resp_set;
      if (st_q == ST_IDLE && req_valid_i) begin
        r_write_q <= req_write_i;
        r_word_q  <= req_word_i;
        r_addr_q  <= req_addr_i;
        r_wdata_q <= req_wdata_i;
      end
      if (st_q == ST_LOOKUP) vic_q <= vic_d;
      if (resp_set) begin
        resp_hit_q   <= resp_hit_d;
        resp_rdata_q <= resp_data_d;
      end
    end
  end

  assign resp_valid_o = resp_valid_q;
  assign resp_hit_o   = resp_hit_q;
  assign resp_rdata_o = resp_rdata_q;
endmodule

// File: rtl/sa2_wb_cache.sv
module sa2_wb_cache
  import sa2c_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic                req_write_i,
  input  logic                req_word_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic [LINE_W-1:0]   req_wdata_i,
  output logic                resp_valid_o,
  output logic                resp_hit_o,
  output logic [LINE_W-1:0]   resp_rdata_o,
  output logic                mem_req_valid_o,
  input  logic                mem_req_ready_i,
  output logic                mem_req_write_o,
  output logic [LADDR_W-1:0]  mem_req_addr_o,
  output logic [LINE_W-1:0]   mem_req_wdata_o,
  input  logic                mem_rsp_valid_i,
  input  logic [LINE_W-1:0]   mem_rsp_data_i
);
  logic [IDX_W-1:0]             set_w;
  tag_t                         tag_w;
  logic [WAYS-1:0]              hit_w, vld_w, dirty_w;
  logic [WAYS-1:0][TAG_W-1:0]   vtag_w;
  logic [WAYS-1:0][LINE_W-1:0]  rline_w;
  logic [WAY_W-1:0]             lru_w, wr_way_w, lru_used_w;
  logic                         tag_we_w, wr_dirty_w, data_we_w, lru_upd_w;
  line_t                        wline_w;

  sa2c_ctrl u_ctrl (
    .clk_i, .rst_ni,
    .req_valid_i, .req_ready_o, .req_write_i, .req_word_i, .req_addr_i, .req_wdata_i,
    .resp_valid_o, .resp_hit_o, .resp_rdata_o,
    .mem_req_valid_o, .mem_req_ready_i, .mem_req_write_o, .mem_req_addr_o,
    .mem_req_wdata_o, .mem_rsp_valid_i, .mem_rsp_data_i,
    .set_o      (set_w),
    .tag_o      (tag_w),
    .hit_i      (hit_w),
    .vld_i      (vld_w),
    .dirty_i    (dirty_w),
    .vtag_i     (vtag_w),
    .rline_i    (rline_w),
    .lru_i      (lru_w),
    .tag_we_o   (tag_we_w),
    .wr_way_o   (wr_way_w),
    .wr_dirty_o (wr_dirty_w),
    .data_we_o  (data_we_w),
    .wline_o    (wline_w),
    .lru_upd_o  (lru_upd_w),
    .lru_used_o (lru_used_w)
  );

  sa2c_tag_store u_tags (
    .clk_i, .rst_ni,
    .set_i      (set_w),
    .tag_i      (tag_w),
    .hit_o      (hit_w),
    .vld_o      (vld_w),
    .dirty_o    (dirty_w),
    .vtag_o     (vtag_w),
    .we_i       (tag_we_w),
    .way_i      (wr_way_w),
    .wr_dirty_i (wr_dirty_w)
  );

  sa2c_lru u_lru (
    .clk_i, .rst_ni,
    .set_i  (set_w),
    .upd_i  (lru_upd_w),
    .used_i (lru_used_w),
    .lru_o  (lru_w)
  );

  sa2c_line_store u_lines (
    .clk_i,
    .set_i   (set_w),
    .we_i    (data_we_w),
    .way_i   (wr_way_w),
    .wline_i (wline_w),
    .rline_o (rline_w)
  );
endmodule

// File: rtl/sa2c_chk.sv
module sa2c_chk
  import sa2c_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_valid_i,
  input logic                req_ready_o,
  input logic                resp_valid_o,
  input logic                mem_req_valid_o,
  input logic                mem_req_ready_i,
  input logic                mem_req_write_o,
  input logic [LADDR_W-1:0]  mem_req_addr_o,
  input logic [LINE_W-1:0]   mem_req_wdata_o
);
  // R11
  busy_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  // R11
  resp_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |=> !resp_valid_o);

  // R12
  mem_req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=>
      (mem_req_valid_o && $stable(mem_req_addr_o) && $stable(mem_req_write_o)
       && $stable(mem_req_wdata_o)));

  // R8
  wb_before_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && mem_req_ready_i && mem_req_write_o) |=>
      (mem_req_valid_o && !mem_req_write_o));

  // R7
  mem_only_when_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> !req_ready_o);

  // R2
  resp_needs_request_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> !$past(req_ready_o));
endmodule

bind sa2_wb_cache sa2c_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_valid_i     (req_valid_i),
  .req_ready_o     (req_ready_o),
  .resp_valid_o    (resp_valid_o),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_ready_i (mem_req_ready_i),
  .mem_req_write_o (mem_req_write_o),
  .mem_req_addr_o  (mem_req_addr_o),
  .mem_req_wdata_o (mem_req_wdata_o)
);

// File: tb/sa2_wb_cache_tb.sv
`timescale 1ns/1ps
module sa2_wb_cache_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, resp_valid, resp_hit;
  logic [31:0] resp_rdata;
  logic        mreq_valid, mreq_ready, mreq_write;
  logic [9:0]  mreq_addr;
  logic [31:0] mreq_wdata;
  logic        mrsp_valid;
  logic [31:0] mrsp_data;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sa2_wb_cache u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_word_i(req_word), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .resp_valid_o(resp_valid), .resp_hit_o(resp_hit), .resp_rdata_o(resp_rdata),
    .mem_req_valid_o(mreq_valid), .mem_req_ready_i(mreq_ready),
    .mem_req_write_o(mreq_write), .mem_req_addr_o(mreq_addr),
    .mem_req_wdata_o(mreq_wdata), .mem_rsp_valid_i(mrsp_valid),
    .mem_rsp_data_i(mrsp_data)
  );

  // ---------------- memory model ----------------
  logic [31:0] mem [1024];
  bit          mem_init = 1'b0;
  logic        pend = 1'b0;
  logic [9:0]  pend_addr = '0;
  int          wb_cnt = 0, rd_cnt = 0, evt = 0, wb_evt = 0, rd_evt = 0;
  logic [9:0]  wb_addr = '0;
  logic [31:0] wb_data = '0;
  bit          stall_en = 1'b0;
  int          stall_cnt = 0;

  function automatic logic [31:0] seed(int i);
    logic [9:0] a;
    a = i[9:0];
    return {6'h2B, a, 6'h15, a ^ 10'h3A5};
  endfunction

  assign mreq_ready = !(stall_en && stall_cnt < 3);
  assign mrsp_valid = pend;
  assign mrsp_data  = mem[pend_addr];

  always @(posedge clk) begin
    pend <= 1'b0;
    if (!stall_en) stall_cnt <= 0;
    else if (mreq_valid && stall_cnt < 3) stall_cnt <= stall_cnt + 1;
    if (!mem_init) begin
      for (int i = 0; i < 1024; i++) mem[i] <= seed(i);
      mem_init <= 1'b1;
    end else if (mreq_valid && mreq_ready) begin
      evt <= evt + 1;
      if (mreq_write) begin
        mem[mreq_addr] <= mreq_wdata;
        wb_cnt  <= wb_cnt + 1;
        wb_addr <= mreq_addr;
        wb_data <= mreq_wdata;
        wb_evt  <= evt;
      end else begin
        rd_cnt    <= rd_cnt + 1;
        rd_evt    <= evt;
        pend      <= 1'b1;
        pend_addr <= mreq_addr;
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] byte_of(logic [31:0] w, int o);
    return {24'h0, w[o*8 +: 8]};
  endfunction

  task automatic acc(input string tag, input logic w, input logic wd,
                     input logic [11:0] a, input logic [31:0] d,
                     input logic exp_hit, input logic chk_dat,
                     input logic [31:0] exp_dat, input int exp_lat);
    int lat;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_word = wd; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!resp_valid && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    chk({tag, " hit"}, {31'h0, resp_hit}, {31'h0, exp_hit});
    if (chk_dat) chk({tag, " data"}, resp_rdata, exp_dat);
    chk({tag, " R11 latency"}, lat, exp_lat);
  endtask

  // ---------------- scenarios ----------------
  logic [31:0] merged;

  task automatic t_reset_state();
    chk("R2 ready in reset", {31'h0, req_ready}, 32'h1);
    chk("R2 resp idle", {31'h0, resp_valid}, 32'h0);
    chk("R2 mem idle", {31'h0, mreq_valid}, 32'h0);
  endtask

  task automatic t_fill_and_spatial();
    acc("R2 R5 R10 first byte miss", 0, 0, 12'h8E2, 0, 0, 1, byte_of(seed(12'h238), 2), 4);
    acc("R5 R10 same line word hit", 0, 1, 12'h8E0, 0, 1, 1, seed(12'h238), 2);
  endtask

  task automatic t_empty_way_and_coexist();
    acc("R3 second tag fills empty way", 0, 0, 12'h8E8, 0, 0, 1, byte_of(seed(12'h23A), 0), 4);
    acc("R13 first tag still hits", 0, 0, 12'h8E2, 0, 1, 1, byte_of(seed(12'h238), 2), 2);
    acc("R13 second tag hits", 0, 0, 12'h8E9, 0, 1, 1, byte_of(seed(12'h23A), 1), 2);
  endtask

  task automatic t_set_isolation();
    acc("R1 other set miss", 0, 0, 12'hDF7, 0, 0, 1, byte_of(seed(12'h37D), 3), 4);
    acc("R1 set0 way0 kept", 0, 1, 12'h8E0, 0, 1, 1, seed(12'h238), 2);
    acc("R1 set0 way1 kept", 0, 1, 12'h8E8, 0, 1, 1, seed(12'h23A), 2);
  endtask

  task automatic t_lru_replace();
    int w0;
    w0 = wb_cnt;
    acc("R4 R6 miss evicts LRU way", 0, 1, 12'hAB8, 0, 0, 1, seed(12'h2AE), 4);
    chk("R8 clean victim no write", wb_cnt, w0);
    acc("R4 MRU line survives", 0, 1, 12'h8E8, 0, 1, 1, seed(12'h23A), 2);
    acc("R4 evicted line misses", 0, 1, 12'h8E0, 0, 0, 1, seed(12'h238), 4);
  endtask

  task automatic t_store_hit();
    int w0, r0;
    w0 = wb_cnt; r0 = rd_cnt;
    merged = seed(12'h23A);
    merged[15:8] = 8'h77;
    acc("R7 byte store hit", 1, 0, 12'h8E9, 32'hFFFF_FF77, 1, 0, 0, 2);
    chk("R7 no write-back", wb_cnt, w0);
    chk("R7 no refill", rd_cnt, r0);
    chk("R7 memory untouched", mem[12'h23A], seed(12'h23A));
    acc("R10 merged lane readback", 0, 1, 12'h8E8, 0, 1, 1, merged, 2);
  endtask

  task automatic t_dirty_evict();
    int w0;
    w0 = wb_cnt;
    acc("R8 clean victim first", 0, 1, 12'hAB8, 0, 0, 1, seed(12'h2AE), 4);
    chk("R8 clean no write", wb_cnt, w0);
    acc("R8 dirty victim evict", 0, 1, 12'hAB0, 0, 0, 1, seed(12'h2AC), 5);
    chk("R8 one write-back", wb_cnt, w0 + 1);
    chk("R8 write-back addr", {22'h0, wb_addr}, 32'h23A);
    chk("R8 write-back data", wb_data, merged);
    chk("R8 write-back before refill", {31'h0, wb_evt < rd_evt}, 32'h1);
    acc("R8 evicted data from memory", 0, 1, 12'h8E8, 0, 0, 1, merged, 4);
  endtask

  task automatic t_store_miss();
    int w0;
    w0 = wb_cnt;
    acc("R9 word store miss", 1, 1, 12'h5F4, 32'hDEAD_BEEF, 0, 0, 0, 4);
    acc("R9 allocated line", 0, 1, 12'h5F4, 0, 1, 1, 32'hDEAD_BEEF, 2);
    acc("R6 touch way0 set1", 0, 0, 12'hDF7, 0, 1, 1, byte_of(seed(12'h37D), 3), 2);
    acc("R9 dirty alloc evicted", 0, 1, 12'h3F4, 0, 0, 1, seed(12'h0FD), 5);
    chk("R9 write-back addr", {22'h0, wb_addr}, 32'h17D);
    chk("R9 write-back data", wb_data, 32'hDEAD_BEEF);
    chk("R9 write-back count", wb_cnt, w0 + 1);
    acc("R9 byte store miss", 1, 0, 12'h5F6, 32'h0000_003C, 0, 0, 0, 4);
    acc("R9 R10 byte merged after refill", 0, 1, 12'h5F4, 0, 1, 1, 32'hDE3C_BEEF, 2);
  endtask

  task automatic t_stall();
    stall_en = 1'b1;
    acc("R12 stalled refill", 0, 1, 12'h1F4, 0, 0, 1, seed(12'h07D), 7);
    stall_en = 1'b0;
  endtask

  task automatic t_reset_drop();
    int w0;
    acc("R2 make set0 dirty", 1, 0, 12'h8EA, 32'h11, 1, 0, 0, 2);
    w0 = wb_cnt;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    acc("R2 line invalid after reset", 0, 1, 12'h8E8, 0, 0, 1, merged, 4);
    acc("R2 dirty set1 line dropped", 0, 1, 12'h5F4, 0, 0, 1, 32'hDEAD_BEEF, 4);
    chk("R2 no write-back of dropped", wb_cnt, w0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    t_fill_and_spatial();
    t_empty_way_and_coexist();
    t_set_isolation();
    t_lru_replace();
    t_store_hit();
    t_dirty_evict();
    t_store_miss();
    t_stall();
    t_reset_drop();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      vectors++;
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule